// File: doc/BRIEF.md
# Serial-Clocked Wiper Stepper

This block is the fine-adjust engine behind a serial-bus-controlled digital potentiometer. Once the command decoder has acknowledged an instruction byte, it hands the byte to the stepper. If the byte is a step instruction for an existing wiper, the stepper takes control of that wiper's 8-bit code. From then on the bus carries no bytes and no acknowledges. Every clock pulse on the serial bus is one step command, and the level of the data line while the clock is high gives its direction.

The stepper owns no wiper storage. It reads the current codes of all wipers from the register bank and returns one update per pulse: a valid strobe, the wiper index and the new code. The bank writes that code into its volatile wiper register only. The mode ends on the next STOP or START. A pulse cut short by either of them produces no step. Codes saturate at both ends of the range.

Top module: `wiper_stepper`

## Requirements
- R1: Step mode is entered only by a cycle with `instr_valid` high whose `instr_byte` has bits [7:4] = 4'b0010, bits [3:2] = 2'b00 and bits [1:0] (the wiper index) below `NUM_POTS`. Any other byte, and any clock pulse while the mode is off, produces no update.
- R2: A pulse whose data level was 1 on the `scl_rise` strobe raises the selected code by one. The update appears as `upd_valid` high for one cycle, in the cycle after the `scl_fall` strobe.
- R3: A pulse whose data level was 0 on the `scl_rise` strobe lowers the selected code by one, with the same timing as R2.
- R4: Rising and falling steps may be mixed in any number within one session. Each completed pulse yields exactly one update, computed from the code the bank holds at that moment.
- R5: A rising step from 255 returns 255, and a falling step from 0 returns 0. The code never wraps.
- R6: A `stop_det` strobe ends the mode. Later pulses produce no update until a new step instruction arrives.
- R7: A `start_det` or `stop_det` strobe between a pulse's `scl_rise` and its `scl_fall` cancels that step and ends the mode.
- R8: `upd_pot` always names the wiper chosen by the instruction. The codes of other wipers are never reported as changed.
- R9: After reset the mode is off and `upd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Acknowledged instruction byte is present |
| instr_byte | input | 8 | Instruction byte: opcode [7:4], register field [3:2], wiper index [1:0] |
| scl_rise | input | 1 | Synchronized bus-clock rising-edge strobe |
| scl_fall | input | 1 | Synchronized bus-clock falling-edge strobe |
| sda_lvl | input | 1 | Synchronized data-line level |
| start_det | input | 1 | START condition strobe |
| stop_det | input | 1 | STOP condition strobe |
| wcr_flat | input | NUM_POTS*CODE_W | Current wiper codes, wiper i at bits [i*CODE_W +: CODE_W] |
| upd_valid | output | 1 | One-cycle update strobe |
| upd_pot | output | 2 | Index of the wiper being updated |
| upd_code | output | CODE_W | New code for that wiper |

## Verification
The bench builds the block with its default values: CODE_W = 8 and NUM_POTS = 2. Eight-bit codes let a sweep walk one wiper through all 256 positions in both directions and push past each end, so every code value and both saturation points are checked against arithmetic expected values. Two wipers are enough to show that the unselected wiper is never touched. They also leave index 2 as an out-of-range value for the instruction filter.

// File: rtl/wstep_pkg.sv
package wstep_pkg;
    localparam int BYTE_W      = 8;
    localparam int POT_FIELD_W = 2;
    localparam logic [3:0] OP_STEP  = 4'b0010;
    localparam logic [1:0] REG_NONE = 2'b00;
endpackage

// File: rtl/wstep_decode.sv
module wstep_decode
    import wstep_pkg::*;
#(
    parameter int NUM_POTS = 2
) (
    input  logic                   instr_valid,
    input  logic [BYTE_W-1:0]      instr_byte,
    output logic                   arm,
    output logic [POT_FIELD_W-1:0] arm_pot
);
    logic op_hit;
    logic reg_hit;
    logic pot_hit;

    always_comb begin
        op_hit  = (instr_byte[7:4] == OP_STEP);
        reg_hit = (instr_byte[3:2] == REG_NONE);
        pot_hit = (int'(instr_byte[1:0]) < NUM_POTS);
        arm     = instr_valid && op_hit && reg_hit && pot_hit;
        arm_pot = instr_byte[1:0];
    end
endmodule

// File: rtl/wstep_sat.sv
module wstep_sat #(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] cur,
    input  logic              up,
    output logic [CODE_W-1:0] nxt
);
    localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] BOT = '0;
    localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

    always_comb begin
        if (up) begin
            nxt = (cur == TOP) ? TOP : cur + ONE;
        end else begin
            nxt = (cur == BOT) ? BOT : cur - ONE;
        end
    end
endmodule

// File: rtl/wiper_stepper.sv
module wiper_stepper
    import wstep_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int NUM_POTS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       instr_valid,
    input  logic [7:0]                 instr_byte,
    input  logic                       scl_rise,
    input  logic                       scl_fall,
    input  logic                       sda_lvl,
    input  logic                       start_det,
    input  logic                       stop_det,
    input  logic [NUM_POTS*CODE_W-1:0] wcr_flat,
    output logic                       upd_valid,
    output logic [1:0]                 upd_pot,
    output logic [CODE_W-1:0]          upd_code
);
    localparam int SEL_W = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1;

    typedef struct packed {
        logic                   active;
        logic                   pend;
        logic                   dir;
        logic [POT_FIELD_W-1:0] pot;
        logic                   valid;
        logic [CODE_W-1:0]      code;
    } step_st_t;

    step_st_t st_d, st_q;

    logic                   arm;
    logic [POT_FIELD_W-1:0] arm_pot;
    logic [CODE_W-1:0]      cur_arr [NUM_POTS];
    logic [CODE_W-1:0]      cur_sel;
    logic [CODE_W-1:0]      stepped;

    wstep_decode #(.NUM_POTS(NUM_POTS)) u_decode (
        .instr_valid (instr_valid),
        .instr_byte  (instr_byte),
        .arm         (arm),
        .arm_pot     (arm_pot)
    );

    for (genvar gi = 0; gi < NUM_POTS; gi++) begin : g_unpack
        assign cur_arr[gi] = wcr_flat[gi*CODE_W +: CODE_W];
    end

    assign cur_sel = cur_arr[st_q.pot[SEL_W-1:0]];

    wstep_sat #(.CODE_W(CODE_W)) u_sat (
        .cur (cur_sel),
        .up  (st_q.dir),
        .nxt (stepped)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (stop_det || start_det) begin
            st_d.active = 1'b0;
            st_d.pend   = 1'b0;
        end else if (arm) begin
            st_d.active = 1'b1;
            st_d.pend   = 1'b0;
            st_d.pot    = arm_pot;
        end else if (st_q.active) begin
            if (scl_rise) begin
                st_d.pend = 1'b1;
                st_d.dir  = sda_lvl;
            end else if (scl_fall && st_q.pend) begin
                st_d.pend  = 1'b0;
                st_d.valid = 1'b1;
                st_d.code  = stepped;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign upd_valid = st_q.valid;
    assign upd_pot   = st_q.pot;
    assign upd_code  = st_q.code;
endmodule

// File: rtl/wiper_stepper_chk.sv
module wiper_stepper_chk #(
    parameter int CODE_W   = 8,
    parameter int NUM_POTS = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       scl_fall,
    input logic                       start_det,
    input logic                       stop_det,
    input logic [NUM_POTS*CODE_W-1:0] wcr_flat,
    input logic                       upd_valid,
    input logic [1:0]                 upd_pot,
    input logic [CODE_W-1:0]          upd_code
);
    localparam int MAXC = (1 << CODE_W) - 1;

    logic [NUM_POTS*CODE_W-1:0] wcr_q;
    int prev_cur;
    int new_code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wcr_q <= '0;
        else        wcr_q <= wcr_flat;
    end

    always_comb begin
        prev_cur = 0;
        for (int i = 0; i < NUM_POTS; i++) begin
            if (int'(upd_pot) == i) prev_cur = int'(wcr_q[i*CODE_W +: CODE_W]);
        end
        new_code = int'(upd_code);
    end

    p_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> $past(scl_fall));

    p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (new_code == prev_cur + 1 || new_code == prev_cur - 1 || new_code == prev_cur));

    p_no_wrap_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && new_code == 0) |-> (prev_cur <= 1));

    p_no_wrap_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && prev_cur == MAXC) |-> (new_code >= MAXC - 1));

    p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> !upd_valid);

    p_pot_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (int'(upd_pot) < NUM_POTS));
endmodule

bind wiper_stepper wiper_stepper_chk #(.CODE_W(CODE_W), .NUM_POTS(NUM_POTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .wcr_flat  (wcr_flat),
    .upd_valid (upd_valid),
    .upd_pot   (upd_pot),
    .upd_code  (upd_code)
);

// File: tb/tb_wiper_stepper.sv
module tb_wiper_stepper;
    localparam int CLK_PERIOD = 10;
    localparam int CW   = 8;
    localparam int NP   = 2;
    localparam int MAXC = 255;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          instr_valid = 0;
    logic [7:0]    instr_byte = '0;
    logic          scl_rise = 0, scl_fall = 0, sda_lvl = 0;
    logic          start_det = 0, stop_det = 0;
    logic [NP*CW-1:0] wcr_flat;
    logic          upd_valid;
    logic [1:0]    upd_pot;
    logic [CW-1:0] upd_code;

    int model [NP];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < NP; i++) wcr_flat[i*CW +: CW] = CW'(model[i]);
    end

    wiper_stepper #(.CODE_W(CW), .NUM_POTS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_byte(instr_byte),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
        .start_det(start_det), .stop_det(stop_det), .wcr_flat(wcr_flat),
        .upd_valid(upd_valid), .upd_pot(upd_pot), .upd_code(upd_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_instr(input logic [7:0] b);
        @(negedge clk); instr_valid = 1; instr_byte = b;
        @(negedge clk); instr_valid = 0;
    endtask

    task automatic send_stop();
        @(negedge clk); stop_det = 1;
        @(negedge clk); stop_det = 0;
    endtask

    // One pulse; when expect_step is set, checks the stepped code of wiper pot
    task automatic pulse(input bit up, input bit expect_step, input int pot, input string req);
        int exp_code;
        int other;
        @(negedge clk); scl_rise = 1; sda_lvl = up;
        @(negedge clk); scl_rise = 0;
        @(negedge clk); sda_lvl = ~up;
        @(negedge clk); scl_fall = 1;
        @(negedge clk); scl_fall = 0;
        if (expect_step) begin
            exp_code = up ? ((model[pot] == MAXC) ? MAXC : model[pot] + 1)
                          : ((model[pot] == 0) ? 0 : model[pot] - 1);
            check(upd_valid == 1'b1, req, int'(upd_valid), 1);
            check(int'(upd_pot) == pot, {req, "/R8 pot"}, int'(upd_pot), pot);
            check(int'(upd_code) == exp_code, req, int'(upd_code), exp_code);
            if (upd_valid) begin
                other = model[1-pot];
                model[int'(upd_pot) % NP] = int'(upd_code);
                check(model[1-pot] == other, "R8 other wiper", model[1-pot], other);
            end
        end else begin
            check(upd_valid == 1'b0, req, int'(upd_valid), 0);
        end
        @(negedge clk);
        check(upd_valid == 1'b0, {req, " single strobe"}, int'(upd_valid), 0);
    endtask

    initial begin
        model[0] = 8'h80;
        model[1] = 5;
        repeat (3) @(negedge clk);
        check(upd_valid == 1'b0, "R9 reset", int'(upd_valid), 0);
        rst_n = 1;
        @(negedge clk);
        check(upd_valid == 1'b0, "R9 after reset", int'(upd_valid), 0);

        // R1: pulses before any instruction
        pulse(1, 0, 0, "R1 idle");
        // R1: rejected bytes (register field, out-of-range wiper, other opcode)
        send_instr(8'h25); pulse(1, 0, 0, "R1 reg field");
        send_instr(8'h22); pulse(1, 0, 0, "R1 wiper range");
        send_instr(8'hA1); pulse(0, 0, 0, "R1 opcode");
        send_instr(8'h21); send_instr(8'h00); // valid arm, then a byte that is not an instruction
        send_stop();

        // R3/R5: wiper 1 from 5 down past zero
        send_instr(8'h21);
        for (int i = 0; i < 8; i++) pulse(0, 1, 1, "R3 down");
        check(model[1] == 0, "R5 low sat", model[1], 0);
        // R2/R5: full sweep up past 255
        for (int i = 0; i < 260; i++) pulse(1, 1, 1, "R2 up");
        check(model[1] == MAXC, "R5 high sat", model[1], MAXC);
        // R3: full sweep down
        for (int i = 0; i < 256; i++) pulse(0, 1, 1, "R3 down sweep");
        check(model[1] == 0, "R3 reach zero", model[1], 0);
        // R4: mixed pattern in the same session
        for (int i = 0; i < 30; i++) pulse((i % 3) != 2, 1, 1, "R4 mixed");
        check(model[1] == 10, "R4 net", model[1], 10);
        check(model[0] == 8'h80, "R8 untouched", model[0], 8'h80);
        // R6: stop ends mode
        send_stop();
        pulse(1, 0, 1, "R6 after stop");

        // R7: start during a high pulse cancels and ends the mode
        send_instr(8'h20);
        pulse(1, 1, 0, "R2 wiper0");
        @(negedge clk); scl_rise = 1; sda_lvl = 1;
        @(negedge clk); scl_rise = 0;
        @(negedge clk); start_det = 1;
        @(negedge clk); start_det = 0;
        @(negedge clk); scl_fall = 1;
        @(negedge clk); scl_fall = 0;
        check(upd_valid == 1'b0, "R7 cancel start", int'(upd_valid), 0);
        pulse(1, 0, 0, "R7 mode ended");
        // R7: stop during a high pulse
        send_instr(8'h20);
        @(negedge clk); scl_rise = 1; sda_lvl = 0;
        @(negedge clk); scl_rise = 0; stop_det = 1;
        @(negedge clk); stop_det = 0; scl_fall = 1;
        @(negedge clk); scl_fall = 0;
        check(upd_valid == 1'b0, "R7 cancel stop", int'(upd_valid), 0);
        check(model[0] == 8'h81, "R7 code kept", model[0], 8'h81);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule